// File: doc/BRIEF.md
# Byte-to-Word Host Port Bridge

This block is a slave port between an 8-bit external host bus and a 24-bit internal processor bus. It carries words in both directions at the same time. The host sees eight byte locations that it selects with a 3-bit address. Three of them hold the bytes of a data word, from high to low. The other locations give host control, host status and a command mailbox. The internal processor sees three word locations: control/status, transmit and receive.

Each direction is double buffered. A word the host completes goes into the internal receive register. If that register is still full, the word waits in the host byte stage until the internal side reads. An internal transmit word goes into the host-readable bytes. If those bytes are still full, the word waits in the transmit register until the host reads the low byte. A request/acknowledge pair lets an external DMA engine move data without an address. Acknowledged cycles step through the data bytes from high to low.

The port enable bit clears all transfer state, both after a hardware reset and when software writes it to 0. While the port is disabled, no output drives the host bus or raises a request.

Top module: `byte_word_bridge`

## Requirements
- R1: After reset, h_oe, h_req and c_irq are 0. An internal read of the control word (c_addr 0) returns 24'h000020: only the transmit-empty bit 5 is set.
- R2: When the host writes bytes to addresses 5 (high), 6 (middle) and 7 (low) while the port is enabled, the internal receive word (c_addr 2) becomes {high, middle, low}. Receive-full (control bit 4) is set by the low-byte write and cleared by the internal read of c_addr 2.
- R3: A word that the host completes while receive-full is set is held. Host status bit 1 (host write buffer empty) reads 0 and further host data writes are ignored. The held word is delivered by the next internal receive read.
- R4: An internal write to c_addr 1 makes its bytes readable by the host at addresses 5, 6 and 7, and sets host status bit 0. The host read of address 7 clears that bit.
- R5: An internal transmit word written while host status bit 0 is set is held. Control bit 5 reads 0 and further transmit writes are ignored. The held word moves to the host bytes when the host reads address 7.
- R6: A low-byte write on its own completes a word, reusing the high and middle bytes written earlier, so 8-, 16- and 24-bit transfers can be mixed.
- R7: While control bit 0 (port enable) is 0, h_oe and h_req stay 0. Host accesses are ignored, and all full flags and pending words are cleared.
- R8: A host write of bit 0 set to address 2 sets the command flag (control bit 4's neighbour, bit 3, and host status bit 2). This raises c_irq. An internal control write with bit 3 set clears the command flag.
- R9: h_req is 1 when host control bit 0 (address 0) is set and host status bit 0 is set, or when host control bit 1 is set and host status bit 1 is set.
- R10: With h_ack high, host data cycles ignore h_addr and use the data bytes in the order high, middle, low, separately for reads and writes.
- R11: c_irq is also raised by receive-full when control bit 1 is set, and by transmit-empty when control bit 2 is set.
- R12: h_oe is 1 exactly during enabled host read cycles (h_en and h_rw high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_en | input | 1 | Host cycle enable |
| h_rw | input | 1 | Host read (1) or write (0) |
| h_addr | input | 3 | Host byte location |
| h_ack | input | 1 | Host acknowledge, address-free data cycle |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_oe | output | 1 | Host bus drive enable |
| h_req | output | 1 | Host service request |
| c_sel | input | 1 | Internal access strobe |
| c_we | input | 1 | Internal write (1) or read (0) |
| c_addr | input | 2 | Internal word: 0 control, 1 transmit, 2 receive |
| c_wdata | input | 24 | Internal write word |
| c_rdata | output | 24 | Internal read word |
| c_irq | output | 1 | Interrupt request toward the processor |

## Verification
The assertions check on every cycle that the port is silent while disabled, and that h_oe only accompanies host reads. They also check that a pending command always raises the interrupt. Each full flag must rise only after its filling access, and fall only after its draining access or a disable. Only the bench scenarios can show byte order and the contents of held words. They also show the result of partial transfers, the DMA byte sequence and the exact levels of h_req under each host control setting.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
   typedef enum logic [1:0] {
      CW_CTRL = 2'd0,
      CW_TX   = 2'd1,
      CW_RX   = 2'd2
   } cword_e;

   localparam int HA_HCTL = 0;
   localparam int HA_HSTS = 1;
   localparam int HA_HCMD = 2;
endpackage

// File: rtl/bwb_h2c.sv
module bwb_h2c #(
   parameter int BYTE_W = 8,
   parameter int BYTES  = 3,
   localparam int WORD_W = BYTE_W * BYTES,
   localparam int LW     = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [LW-1:0]     wr_lane,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              take,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_full,
   output logic              pend
);
   logic [WORD_W-1:0] word_cur;
   logic [WORD_W-1:0] commit_word;
   logic              commit;

   assign commit = wr_en && !pend && (wr_lane == '0);

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       byte_q <= '0;
         else if (clr)                                     byte_q <= '0;
         else if (wr_en && !pend && wr_lane == LW'(g))     byte_q <= wr_byte;
      end
      assign word_cur[g*BYTE_W +: BYTE_W] = byte_q;
   end

   always_comb begin
      commit_word               = word_cur;
      commit_word[BYTE_W-1:0]   = wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word <= '0;
         rx_full <= 1'b0;
         pend    <= 1'b0;
      end else if (clr) begin
         rx_word <= '0;
         rx_full <= 1'b0;
         pend    <= 1'b0;
      end else if (commit) begin
         if (!rx_full || take) begin
            rx_word <= commit_word;
            rx_full <= 1'b1;
         end else begin
            pend <= 1'b1;
         end
      end else if (take && rx_full) begin
         if (pend) begin
            rx_word <= word_cur;
            pend    <= 1'b0;
         end else begin
            rx_full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bwb_c2h.sv
module bwb_c2h #(
   parameter int BYTE_W = 8,
   parameter int BYTES  = 3,
   localparam int WORD_W = BYTE_W * BYTES,
   localparam int LW     = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rd_en,
   input  logic [LW-1:0]     rd_lane,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              hfull,
   output logic              tx_full
);
   logic [WORD_W-1:0] hword_q;
   logic [WORD_W-1:0] tx_word_q;
   logic              drain;
   logic              accept;

   assign drain  = rd_en && (rd_lane == '0) && hfull;
   assign accept = load && !tx_full;

   always_comb begin
      rd_byte = '0;
      for (int k = 0; k < BYTES; k++) begin
         if (rd_lane == LW'(k)) rd_byte = hword_q[k*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hword_q   <= '0;
         tx_word_q <= '0;
         hfull     <= 1'b0;
         tx_full   <= 1'b0;
      end else if (clr) begin
         hword_q   <= '0;
         tx_word_q <= '0;
         hfull     <= 1'b0;
         tx_full   <= 1'b0;
      end else if (accept) begin
         if (!hfull || drain) begin
            hword_q <= load_word;
            hfull   <= 1'b1;
         end else begin
            tx_word_q <= load_word;
            tx_full   <= 1'b1;
         end
      end else if (drain) begin
         if (tx_full) begin
            hword_q <= tx_word_q;
            tx_full <= 1'b0;
         end else begin
            hfull <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
   import bwb_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int BYTES   = 3,
   parameter int HADDR_W = 3,
   localparam int WORD_W   = BYTE_W * BYTES,
   localparam int LW       = (BYTES > 1) ? $clog2(BYTES) : 1,
   localparam int TOP_ADDR = (1 << HADDR_W) - 1,
   localparam int DATA_BASE = (1 << HADDR_W) - BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h_en,
   input  logic               h_rw,
   input  logic [HADDR_W-1:0] h_addr,
   input  logic               h_ack,
   input  logic [BYTE_W-1:0]  h_wdata,
   output logic [BYTE_W-1:0]  h_rdata,
   output logic               h_oe,
   output logic               h_req,
   input  logic               c_sel,
   input  logic               c_we,
   input  logic [1:0]         c_addr,
   input  logic [WORD_W-1:0]  c_wdata,
   output logic [WORD_W-1:0]  c_rdata,
   output logic               c_irq
);
   if (BYTES < 1 || BYTES > (1 << HADDR_W) - 3) begin : g_bad_bytes
      $error("BYTES must leave room for three control locations");
   end
   if (BYTE_W < 3 || WORD_W < 6) begin : g_bad_width
      $error("BYTE_W too narrow for control and status fields");
   end

   logic          port_en, rie, tie, cmd_q;
   logic [1:0]    hctl_q;
   logic [LW-1:0] wr_ptr_q, rd_ptr_q;
   logic          acc, in_data, clr;
   logic [LW-1:0] addr_lane, lane_w, lane_r;
   logic          hw_dat, hr_dat, hr_low;
   logic          hw_ctl, hw_cmd;
   logic          c_wr_ctrl, load, take;
   logic [WORD_W-1:0] rx_word;
   logic          rx_full, pend, hfull, tx_full;
   logic [BYTE_W-1:0] rd_byte;

   assign clr       = !port_en;
   assign acc       = port_en && h_en;
   assign in_data   = (int'(h_addr) >= DATA_BASE);
   assign addr_lane = LW'(HADDR_W'(TOP_ADDR) - h_addr);
   assign lane_w    = h_ack ? wr_ptr_q : addr_lane;
   assign lane_r    = h_ack ? rd_ptr_q : addr_lane;
   assign hw_dat    = acc && !h_rw && (h_ack || in_data);
   assign hr_dat    = acc &&  h_rw && (h_ack || in_data);
   assign hr_low    = hr_dat && (lane_r == '0);
   assign hw_ctl    = acc && !h_rw && !h_ack && (int'(h_addr) == HA_HCTL);
   assign hw_cmd    = acc && !h_rw && !h_ack && (int'(h_addr) == HA_HCMD);

   assign c_wr_ctrl = c_sel && c_we && (c_addr == CW_CTRL);
   assign load      = port_en && c_sel &&  c_we && (c_addr == CW_TX);
   assign take      = port_en && c_sel && !c_we && (c_addr == CW_RX);

   function automatic logic [LW-1:0] step_down(input logic [LW-1:0] p);
      return (p == '0) ? LW'(BYTES - 1) : p - 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_en <= 1'b0;
         rie     <= 1'b0;
         tie     <= 1'b0;
      end else if (c_wr_ctrl) begin
         port_en <= c_wdata[0];
         rie     <= c_wdata[1];
         tie     <= c_wdata[2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hctl_q   <= '0;
         cmd_q    <= 1'b0;
         wr_ptr_q <= LW'(BYTES - 1);
         rd_ptr_q <= LW'(BYTES - 1);
      end else if (clr) begin
         hctl_q   <= '0;
         cmd_q    <= 1'b0;
         wr_ptr_q <= LW'(BYTES - 1);
         rd_ptr_q <= LW'(BYTES - 1);
      end else begin
         if (hw_ctl) hctl_q <= h_wdata[1:0];
         if (hw_cmd && h_wdata[0])          cmd_q <= 1'b1;
         else if (c_wr_ctrl && c_wdata[3])  cmd_q <= 1'b0;
         if (hw_dat && h_ack) wr_ptr_q <= step_down(wr_ptr_q);
         if (hr_dat && h_ack) rd_ptr_q <= step_down(rd_ptr_q);
      end
   end

   bwb_h2c #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_h2c (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(hw_dat), .wr_lane(lane_w), .wr_byte(h_wdata),
      .take(take), .rx_word(rx_word), .rx_full(rx_full), .pend(pend)
   );

   bwb_c2h #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_c2h (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .load(load), .load_word(c_wdata),
      .rd_en(hr_dat), .rd_lane(lane_r), .rd_byte(rd_byte),
      .hfull(hfull), .tx_full(tx_full)
   );

   always_comb begin
      h_rdata = '0;
      if (hr_dat)                             h_rdata = rd_byte;
      else if (int'(h_addr) == HA_HCTL)       h_rdata = {{(BYTE_W-2){1'b0}}, hctl_q};
      else if (int'(h_addr) == HA_HSTS)       h_rdata = {{(BYTE_W-3){1'b0}}, cmd_q, !pend, hfull};
   end

   assign h_oe  = acc && h_rw;
   assign h_req = port_en && ((hctl_q[0] && hfull) || (hctl_q[1] && !pend));

   always_comb begin
      c_rdata = '0;
      if (c_addr == CW_CTRL)
         c_rdata = {{(WORD_W-6){1'b0}}, !tx_full, rx_full, cmd_q, tie, rie, port_en};
      else if (c_addr == CW_RX)
         c_rdata = rx_word;
   end

   assign c_irq = port_en && (cmd_q || (rie && rx_full) || (tie && !tx_full));
endmodule

// File: rtl/bwb_chk.sv
module bwb_chk (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic h_en,
   input logic h_rw,
   input logic h_oe,
   input logic h_req,
   input logic c_irq,
   input logic cmd_q,
   input logic rx_full,
   input logic take,
   input logic hw_dat,
   input logic hfull,
   input logic hr_low,
   input logic load
);
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> (!h_oe && !h_req && !c_irq)); // R7
   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      h_oe |-> (h_en && h_rw)); // R12
   AST_RXF_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(hw_dat)); // R2
   AST_RXF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> ($past(take) || !$past(port_en))); // R2
   AST_HFULL_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hfull) |-> $past(load)); // R4
   AST_HFULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hfull) |-> ($past(hr_low) || !$past(port_en))); // R4
   AST_CMD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && cmd_q) |-> c_irq); // R8
endmodule

bind byte_word_bridge bwb_chk u_chk (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .h_en(h_en), .h_rw(h_rw),
   .h_oe(h_oe), .h_req(h_req), .c_irq(c_irq), .cmd_q(cmd_q),
   .rx_full(rx_full), .take(take), .hw_dat(hw_dat), .hfull(hfull),
   .hr_low(hr_low), .load(load)
);

// File: tb/byte_word_bridge_tb.sv
module byte_word_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_en = 1'b0, h_rw = 1'b0, h_ack = 1'b0;
   logic [2:0]  h_addr = '0;
   logic [7:0]  h_wdata = '0;
   logic [7:0]  h_rdata;
   logic        h_oe, h_req;
   logic        c_sel = 1'b0, c_we = 1'b0;
   logic [1:0]  c_addr = '0;
   logic [23:0] c_wdata = '0;
   logic [23:0] c_rdata;
   logic        c_irq;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   byte_word_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .h_en(h_en), .h_rw(h_rw), .h_addr(h_addr),
      .h_ack(h_ack), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_oe(h_oe),
      .h_req(h_req), .c_sel(c_sel), .c_we(c_we), .c_addr(c_addr),
      .c_wdata(c_wdata), .c_rdata(c_rdata), .c_irq(c_irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic hw(input logic [2:0] a, input logic [7:0] d, input logic ack = 1'b0);
      @(negedge clk);
      h_en = 1'b1; h_rw = 1'b0; h_addr = a; h_wdata = d; h_ack = ack;
      @(negedge clk);
      h_en = 1'b0; h_ack = 1'b0;
   endtask

   task automatic hr(input logic [2:0] a, output logic [7:0] d, output logic oe,
                     input logic ack = 1'b0);
      @(negedge clk);
      h_en = 1'b1; h_rw = 1'b1; h_addr = a; h_ack = ack;
      #1 d = h_rdata; oe = h_oe;
      @(negedge clk);
      h_en = 1'b0; h_rw = 1'b0; h_ack = 1'b0;
   endtask

   task automatic cw(input logic [1:0] a, input logic [23:0] d);
      @(negedge clk);
      c_sel = 1'b1; c_we = 1'b1; c_addr = a; c_wdata = d;
      @(negedge clk);
      c_sel = 1'b0; c_we = 1'b0;
   endtask

   task automatic cr(input logic [1:0] a, output logic [23:0] d);
      @(negedge clk);
      c_sel = 1'b1; c_we = 1'b0; c_addr = a;
      #1 d = c_rdata;
      @(negedge clk);
      c_sel = 1'b0;
   endtask

   task automatic hword(input logic [23:0] w);
      hw(3'd5, w[23:16]);
      hw(3'd6, w[15:8]);
      hw(3'd7, w[7:0]);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [23:0] w, r;
      logic [7:0]  b;
      logic        oe;

      do_reset();
      chk("R1 h_oe", h_oe, 0);
      chk("R1 h_req", h_req, 0);
      chk("R1 c_irq", c_irq, 0);
      cr(2'd0, r); chk("R1 ctrl", r, 32'h20);

      cw(2'd0, 24'h1);
      for (int i = 0; i < 32; i++) begin
         w = 24'(i * 24'h1F3B7 + 24'h5A0C3);
         hword(w);
         cr(2'd0, r); chk("R2 rxf set", r[4], 1);
         cr(2'd2, r); chk("R2 word", r, w);
         cr(2'd0, r); chk("R2 rxf clr", r[4], 0);
      end
      for (int i = 0; i < 32; i++) begin
         w = 24'(i * 24'h2C4D9 ^ 24'hA5F00F);
         cw(2'd1, w);
         hr(3'd1, b, oe); chk("R4 full", b[0], 1);
         chk("R12 oe", oe, 1);
         hr(3'd5, b, oe); chk("R4 hi", b, w[23:16]);
         hr(3'd6, b, oe); chk("R4 mid", b, w[15:8]);
         hr(3'd7, b, oe); chk("R4 lo", b, w[7:0]);
         hr(3'd1, b, oe); chk("R4 clr", b[0], 0);
      end
      @(negedge clk);
      h_en = 1'b1; h_rw = 1'b0; h_addr = 3'd3; #1 chk("R12 write oe", h_oe, 0);
      @(negedge clk); h_en = 1'b0;

      do_reset(); cw(2'd0, 24'h1);
      hword(24'h111111);
      hword(24'h222222);
      hr(3'd1, b, oe); chk("R3 held", b[1], 0);
      hw(3'd5, 8'h99);
      cr(2'd2, r); chk("R3 first", r, 24'h111111);
      hr(3'd1, b, oe); chk("R3 free", b[1], 1);
      cr(2'd2, r); chk("R3 second", r, 24'h222222);
      cr(2'd0, r); chk("R3 rxf", r[4], 0);

      do_reset(); cw(2'd0, 24'h1);
      cw(2'd1, 24'hA1A2A3);
      cw(2'd1, 24'hB1B2B3);
      cr(2'd0, r); chk("R5 txe", r[5], 0);
      cw(2'd1, 24'hC1C2C3);
      hr(3'd5, b, oe); chk("R5 a hi", b, 8'hA1);
      hr(3'd7, b, oe); chk("R5 a lo", b, 8'hA3);
      cr(2'd0, r); chk("R5 txe back", r[5], 1);
      hr(3'd5, b, oe); chk("R5 b hi", b, 8'hB1);
      hr(3'd6, b, oe); chk("R5 b mid", b, 8'hB2);
      hr(3'd7, b, oe); chk("R5 b lo", b, 8'hB3);
      hr(3'd1, b, oe); chk("R5 empty", b[0], 0);

      do_reset(); cw(2'd0, 24'h1);
      hword(24'h123456); cr(2'd2, r);
      hw(3'd7, 8'h78);   cr(2'd2, r); chk("R6 8bit", r, 24'h123478);
      hw(3'd6, 8'hAB); hw(3'd7, 8'hCD); cr(2'd2, r); chk("R6 16bit", r, 24'h12ABCD);

      do_reset(); cw(2'd0, 24'h1);
      chk("R8 idle", c_irq, 0);
      hw(3'd2, 8'h01);
      chk("R8 irq", c_irq, 1);
      cr(2'd0, r); chk("R8 flag", r[3], 1);
      hr(3'd1, b, oe); chk("R8 host flag", b[2], 1);
      cw(2'd0, 24'h9);
      chk("R8 cleared", c_irq, 0);

      do_reset(); cw(2'd0, 24'h1);
      chk("R9 off", h_req, 0);
      hw(3'd0, 8'h02); chk("R9 tx empty", h_req, 1);
      hword(24'h010203); hword(24'h040506);
      chk("R9 tx held", h_req, 0);
      cr(2'd2, r); chk("R9 tx free", h_req, 1);
      cr(2'd2, r);
      hw(3'd0, 8'h01); chk("R9 rx empty", h_req, 0);
      cw(2'd1, 24'h0A0B0C); chk("R9 rx full", h_req, 1);
      hr(3'd7, b, oe); chk("R9 rx drained", h_req, 0);

      do_reset(); cw(2'd0, 24'h1);
      hw(3'd0, 8'hAB, 1'b1); hw(3'd0, 8'hCD, 1'b1); hw(3'd0, 8'hEF, 1'b1);
      cr(2'd2, r); chk("R10 dma write", r, 24'hABCDEF);
      hr(3'd0, b, oe); chk("R10 ctl untouched", b, 0);
      cw(2'd1, 24'h112233);
      hr(3'd1, b, oe, 1'b1); chk("R10 dma hi", b, 8'h11);
      hr(3'd1, b, oe, 1'b1); chk("R10 dma mid", b, 8'h22);
      hr(3'd1, b, oe, 1'b1); chk("R10 dma lo", b, 8'h33);
      hr(3'd1, b, oe); chk("R10 drained", b[0], 0);

      do_reset(); cw(2'd0, 24'h3);
      chk("R11 no rx", c_irq, 0);
      hword(24'h777777); chk("R11 rx irq", c_irq, 1);
      cr(2'd2, r); chk("R11 rx irq off", c_irq, 0);
      cw(2'd0, 24'h5); chk("R11 tx irq", c_irq, 1);
      cw(2'd1, 24'h1); cw(2'd1, 24'h2); chk("R11 tx full", c_irq, 0);

      do_reset(); cw(2'd0, 24'h1);
      hw(3'd0, 8'h01); cw(2'd1, 24'h445566);
      chk("R7 pre", h_req, 1);
      cw(2'd0, 24'h0);
      chk("R7 req", h_req, 0);
      hr(3'd5, b, oe); chk("R7 oe", oe, 0);
      hw(3'd7, 8'h55);
      cw(2'd0, 24'h1);
      cr(2'd0, r); chk("R7 rxf", r[4], 0);
      hr(3'd1, b, oe); chk("R7 status", b, 8'h02);

      done = 1'b1;
      summary();
   end
endmodule